// File: doc/BRIEF.md
# Data Register Byte Packer

This block is the four-slot byte store that sits between a 16-bit processor data register and a byte-wide serial transfer engine. When the processor writes the data register, the block packs one or two bytes into the store. The engine then removes transmit bytes one at a time, oldest first. In the receive direction, the engine deposits bytes one at a time. The processor collects them two at a time through a read that is combinational and takes effect at the next clock edge.

A byte-order input chooses which half of a 16-bit access maps to the lower slot. The block tracks how many slots are filled. It also keeps the level flags that the surrounding status logic needs: receive-ready, transmit-ready, transmit-underflow and overrun. It raises a one-cycle pulse when the processor reads with no received bytes available.

A small state machine sets the direction of the store. It has three states:
- `ST_EMPTY`: nothing is held.
- `ST_TX`: the store holds bytes written by the processor.
- `ST_RX`: the store holds bytes delivered by the engine.

The transitions are:
- `ST_EMPTY`→`ST_TX` on an accepted write.
- `ST_EMPTY`→`ST_RX` on an accepted push.
- `ST_TX`→`ST_EMPTY` when the engine pulls the last byte.
- `ST_RX`→`ST_EMPTY` when a read leaves no byte.

Each of `ST_TX` and `ST_RX` otherwise stays in place as the fill count moves.

Top module: `byte_packer`

## Requirements
- R1: After reset, `fill_cnt` is 0, `buf_state` is 0 (empty; 1 means transmit, 2 means receive), and `rrdy`, `xrdy`, `xudf`, `rovr` and `empty_rd` are all low.
- R2: A 16-bit write shifts the held bytes up two slots and puts the new pair in slots 1 and 0. With `order_swap`=1, `wr_data[15:8]` goes to slot 1 and `wr_data[7:0]` to slot 0; with `order_swap`=0 the two bytes are exchanged. `fill_cnt` rises by 2.
- R3: An 8-bit write shifts the held bytes up one slot and puts `wr_data[7:0]` in slot 0; `fill_cnt` rises by 1.
- R4: An accepted push stores `rx_data` in slot `fill_cnt`, raises `fill_cnt` by 1 and sets `rrdy`.
- R5: In the receive state, `rd_data` carries slot 0 in bits 15:8 and slot 1 in bits 7:0 when `order_swap`=1, and the reverse when it is 0. A slot at or above `fill_cnt` reads as zero. The read then shifts the store down two slots and lowers `fill_cnt` by 2, floored at 0, and the state returns to empty at 0.
- R6: A read outside the receive state returns zero and leaves the fill count unchanged. `empty_rd` is high for exactly the cycle after that read.
- R7: Every write, accepted or not, clears `xudf` and `xrdy`. Every read, empty or not, clears `rrdy` and `rovr`.
- R8: A write that would take `fill_cnt` above 4, or that arrives in the receive state, is dropped: contents and count are unchanged, and `rovr` is set.
- R9: A push when 4 received bytes are held is dropped and sets `rovr`. A push in the transmit state is ignored and touches neither the store nor any flag.
- R10: `tx_data` is the byte in slot `fill_cnt`-1, so the highest filled slot leaves first. A pull in the transmit state lowers `fill_cnt` by 1, and the pull that empties the store sets `xrdy`. A pull outside the transmit state sets `xudf`.
- R11: Only one operation is accepted per cycle, in the priority write, read, pull, push. A lower-priority strobe in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_swap | input | 1 | Byte order for 16-bit accesses |
| wr_word | input | 1 | 16-bit data write strobe |
| wr_byte | input | 1 | 8-bit final-byte write strobe |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Data read strobe |
| rd_data | output | 16 | Read data, valid while `rd_req` is high |
| tx_pull | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Next transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| fill_cnt | output | 3 | Number of filled slots |
| buf_state | output | 2 | 0 empty, 1 transmit, 2 receive |
| rrdy | output | 1 | Receive-ready flag |
| xrdy | output | 1 | Transmit-ready flag |
| xudf | output | 1 | Transmit-underflow flag |
| rovr | output | 1 | Overrun flag |
| empty_rd | output | 1 | One-cycle pulse after an empty read |

## Verification
`rd_data` and `tx_data` are combinational. The bench therefore samples them one nanosecond after driving the strobe, before the clock edge that consumes the byte. `fill_cnt`, `buf_state` and the four flags update on the first rising edge after a strobe. `empty_rd` also appears on that edge. Every strobe is driven on a falling edge and removed just after the next rising edge. The registered results are checked at the following falling edge, half a period after they are due and a full cycle before any later strobe can change them.

// File: rtl/pk_pkg.sv
package pk_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_TX    = 2'd1,
        ST_RX    = 2'd2
    } pk_state_e;

endpackage

// File: rtl/pk_out_mux.sv
module pk_out_mux #(
    parameter int BW    = 8,
    parameter int SLOTS = 4,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*BW-1:0] slots_flat,
    input  logic [CW-1:0]       fill,
    input  logic                order_swap,
    input  logic                rx_mode,
    output logic [2*BW-1:0]     rd_data,
    output logic [BW-1:0]       tx_data
);

    logic [BW-1:0] pick [SLOTS];
    logic [BW-1:0] lo_byte;
    logic [BW-1:0] hi_byte;

    // Transmit select: only the slot just below the fill level contributes.
    for (genvar i = 0; i < SLOTS; i++) begin : g_pick
        assign pick[i] = (fill == CW'(i + 1)) ? slots_flat[i*BW +: BW] : '0;
    end

    always_comb begin
        tx_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            tx_data = tx_data | pick[i];
        end
    end

    // Receive read: slots past the fill level are masked to zero.
    assign lo_byte = (rx_mode && fill >= CW'(1)) ? slots_flat[0 +: BW]  : '0;
    assign hi_byte = (rx_mode && fill >= CW'(2)) ? slots_flat[BW +: BW] : '0;
    assign rd_data = order_swap ? {lo_byte, hi_byte} : {hi_byte, lo_byte};

endmodule

// File: rtl/pk_flags.sv
module pk_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_rrdy,
    input  logic set_xrdy,
    input  logic set_xudf,
    input  logic set_rovr,
    input  logic set_empty,
    input  logic clr_on_wr,
    input  logic clr_on_rd,
    output logic rrdy,
    output logic xrdy,
    output logic xudf,
    output logic rovr,
    output logic empty_rd
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrdy     <= 1'b0;
            xrdy     <= 1'b0;
            xudf     <= 1'b0;
            rovr     <= 1'b0;
            empty_rd <= 1'b0;
        end else begin
            empty_rd <= set_empty;
            if (clr_on_rd)     rrdy <= 1'b0;
            else if (set_rrdy) rrdy <= 1'b1;
            if (clr_on_wr)     xrdy <= 1'b0;
            else if (set_xrdy) xrdy <= 1'b1;
            if (clr_on_wr)     xudf <= 1'b0;
            else if (set_xudf) xudf <= 1'b1;
            if (clr_on_rd)     rovr <= 1'b0;
            else if (set_rovr) rovr <= 1'b1;
        end
    end

    AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_on_wr && clr_on_rd) && !(clr_on_rd && set_rrdy)); // R11

endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
    parameter int BW    = 8,
    parameter int SLOTS = 4,
    localparam int CW   = $clog2(SLOTS + 1),
    localparam int DW   = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          order_swap,
    input  logic          wr_word,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    input  logic          tx_pull,
    output logic [BW-1:0] tx_data,
    input  logic          rx_push,
    input  logic [BW-1:0] rx_data,
    output logic [CW-1:0] fill_cnt,
    output logic [1:0]    buf_state,
    output logic          rrdy,
    output logic          xrdy,
    output logic          xudf,
    output logic          rovr,
    output logic          empty_rd
);
    import pk_pkg::*;

    pk_state_e     state_q, state_d;
    logic [CW-1:0] fill_q, fill_d;
    logic [BW-1:0] slot_q [SLOTS];
    logic [BW-1:0] slot_d [SLOTS];
    logic [SLOTS*BW-1:0] slots_flat;

    // Operation decode with fixed priority.
    logic          any_wr, do_rd, do_pull, do_push;
    logic [CW:0]   add_n, wr_sum;
    logic          wr_fits, wr_take, wr_drop;
    logic          rd_take, rd_none;
    logic          pull_take, pull_none;
    logic          push_take, push_full;
    logic [BW-1:0] pair_hi, pair_lo;

    assign any_wr  = wr_word | wr_byte;
    assign do_rd   = rd_req  & ~any_wr;
    assign do_pull = tx_pull & ~any_wr & ~rd_req;
    assign do_push = rx_push & ~any_wr & ~rd_req & ~tx_pull;

    assign add_n   = wr_word ? (CW+1)'(2) : (CW+1)'(1);
    assign wr_sum  = {1'b0, fill_q} + add_n;
    assign wr_fits = (state_q != ST_RX) && (wr_sum <= (CW+1)'(SLOTS));
    assign wr_take = any_wr & wr_fits;
    assign wr_drop = any_wr & ~wr_fits;

    assign rd_take = do_rd & (state_q == ST_RX);
    assign rd_none = do_rd & (state_q != ST_RX);

    assign pull_take = do_pull & (state_q == ST_TX);
    assign pull_none = do_pull & (state_q != ST_TX);

    assign push_take = do_push & ((state_q == ST_EMPTY) ||
                       ((state_q == ST_RX) && (fill_q < CW'(SLOTS))));
    assign push_full = do_push & (state_q == ST_RX) & (fill_q == CW'(SLOTS));

    assign pair_hi = order_swap ? wr_data[DW-1:BW] : wr_data[BW-1:0];
    assign pair_lo = order_swap ? wr_data[BW-1:0]  : wr_data[DW-1:BW];

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // Next state and fill level.
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_take) begin
                    state_d = ST_TX;
                    fill_d  = CW'(add_n);
                end else if (push_take) begin
                    state_d = ST_RX;
                    fill_d  = CW'(1);
                end
            end
            ST_TX: begin
                if (wr_take) begin
                    fill_d = CW'(wr_sum);
                end else if (pull_take) begin
                    fill_d = fill_q - CW'(1);
                    if (fill_q == CW'(1)) state_d = ST_EMPTY;
                end
            end
            ST_RX: begin
                if (push_take) begin
                    fill_d = fill_q + CW'(1);
                end else if (rd_take) begin
                    if (fill_q <= CW'(2)) begin
                        fill_d  = '0;
                        state_d = ST_EMPTY;
                    end else begin
                        fill_d = fill_q - CW'(2);
                    end
                end
            end
            default: begin
                state_d = ST_EMPTY;
                fill_d  = '0;
            end
        endcase
    end

    // Slot store next value.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) slot_d[i] = slot_q[i];
        if (wr_take && wr_word) begin
            for (int i = SLOTS - 1; i >= 2; i--) slot_d[i] = slot_q[i-2];
            slot_d[1] = pair_hi;
            slot_d[0] = pair_lo;
        end else if (wr_take) begin
            for (int i = SLOTS - 1; i >= 1; i--) slot_d[i] = slot_q[i-1];
            slot_d[0] = wr_data[BW-1:0];
        end else if (rd_take) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_d[i] = (i + 2 < SLOTS) ? slot_q[(i+2) % SLOTS] : '0;
            end
        end else if (push_take) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (fill_q == CW'(i)) slot_d[i] = rx_data;
            end
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
        assign slots_flat[i*BW +: BW] = slot_q[i];
    end

    pk_out_mux #(.BW(BW), .SLOTS(SLOTS)) u_mux (
        .slots_flat (slots_flat),
        .fill       (fill_q),
        .order_swap (order_swap),
        .rx_mode    (state_q == ST_RX),
        .rd_data    (rd_data),
        .tx_data    (tx_data)
    );

    pk_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rrdy  (push_take),
        .set_xrdy  (pull_take && fill_q == CW'(1)),
        .set_xudf  (pull_none),
        .set_rovr  (wr_drop | push_full),
        .set_empty (rd_none),
        .clr_on_wr (any_wr),
        .clr_on_rd (do_rd),
        .rrdy      (rrdy),
        .xrdy      (xrdy),
        .xudf      (xudf),
        .rovr      (rovr),
        .empty_rd  (empty_rd)
    );

    assign fill_cnt  = fill_q;
    assign buf_state = state_q;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(SLOTS)); // R8
    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_state == 2'd0) == (fill_cnt == '0)); // R5
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word || wr_byte) |=> (!xudf && !xrdy)); // R7
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_word && !wr_byte) |=> (!rrdy && !rovr)); // R7
    AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !wr_word && !wr_byte && !rd_req && !tx_pull &&
         buf_state == 2'd2 && fill_cnt == CW'(SLOTS))
        |=> (rovr && fill_cnt == CW'(SLOTS))); // R9
    AST_PULL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pull && !wr_word && !wr_byte && !rd_req && buf_state == 2'd1)
        |=> (fill_cnt == $past(fill_cnt) - CW'(1))); // R10

endmodule

// File: tb/byte_packer_test.sv
`timescale 1ns/1ps
module byte_packer_test;

    localparam logic [2:0] OP_W16 = 3'd0, OP_W8 = 3'd1, OP_PUSH = 3'd2,
                           OP_PULL = 3'd3, OP_RD = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic        ord;
        logic [15:0] din;
        logic [15:0] exp_out;
        logic [2:0]  exp_fill;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{OP_W16,  1'b1, 16'hABCD, 16'h0000, 3'd2},
        '{OP_W16,  1'b1, 16'h1234, 16'h0000, 3'd4},
        '{OP_PULL, 1'b1, 16'h0000, 16'h00AB, 3'd3},
        '{OP_PULL, 1'b1, 16'h0000, 16'h00CD, 3'd2},
        '{OP_PULL, 1'b1, 16'h0000, 16'h0012, 3'd1},
        '{OP_PULL, 1'b1, 16'h0000, 16'h0034, 3'd0},
        '{OP_W16,  1'b0, 16'hABCD, 16'h0000, 3'd2},
        '{OP_PULL, 1'b0, 16'h0000, 16'h00CD, 3'd1},
        '{OP_W8,   1'b0, 16'h005A, 16'h0000, 3'd2},
        '{OP_PULL, 1'b0, 16'h0000, 16'h00AB, 3'd1},
        '{OP_PULL, 1'b0, 16'h0000, 16'h005A, 3'd0},
        '{OP_PUSH, 1'b0, 16'h0011, 16'h0000, 3'd1},
        '{OP_PUSH, 1'b0, 16'h0022, 16'h0000, 3'd2},
        '{OP_PUSH, 1'b0, 16'h0033, 16'h0000, 3'd3},
        '{OP_RD,   1'b1, 16'h0000, 16'h1122, 3'd1},
        '{OP_RD,   1'b0, 16'h0000, 16'h0033, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        order_swap = 1'b0;
    logic        wr_word = 1'b0, wr_byte = 1'b0, rd_req = 1'b0;
    logic        tx_pull = 1'b0, rx_push = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rx_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  tx_data;
    logic [2:0]  fill_cnt;
    logic [1:0]  buf_state;
    logic        rrdy, xrdy, xudf, rovr, empty_rd;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] seen;

    always #2.5 clk = ~clk;

    byte_packer uut (
        .clk(clk), .rst_n(rst_n), .order_swap(order_swap),
        .wr_word(wr_word), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data),
        .tx_pull(tx_pull), .tx_data(tx_data),
        .rx_push(rx_push), .rx_data(rx_data),
        .fill_cnt(fill_cnt), .buf_state(buf_state),
        .rrdy(rrdy), .xrdy(xrdy), .xudf(xudf), .rovr(rovr), .empty_rd(empty_rd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive strobes at a falling edge, capture combinational outputs,
    // release after the rising edge, return at the next falling edge.
    task automatic drive(input logic w16, input logic w8, input logic rd,
                         input logic pl, input logic ps, input logic ord,
                         input logic [15:0] din);
        @(negedge clk);
        wr_word = w16; wr_byte = w8; rd_req = rd; tx_pull = pl; rx_push = ps;
        order_swap = ord; wr_data = din; rx_data = din[7:0];
        #1;
        seen = rd ? rd_data : {8'h00, tx_data};
        @(posedge clk);
        #0.5;
        wr_word = 0; wr_byte = 0; rd_req = 0; tx_pull = 0; rx_push = 0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 fill", fill_cnt, 0);
        check("R1 state", buf_state, 0);
        check("R1 flags", {rrdy, xrdy, xudf, rovr, empty_rd}, 0);

        // Vector table: R2 R3 R4 R5 R10
        for (int i = 0; i < 16; i++) begin
            drive(VECS[i].op == OP_W16, VECS[i].op == OP_W8, VECS[i].op == OP_RD,
                  VECS[i].op == OP_PULL, VECS[i].op == OP_PUSH,
                  VECS[i].ord, VECS[i].din);
            if (VECS[i].op == OP_PULL)
                check($sformatf("R2/R3/R10 vec%0d tx byte", i), seen, VECS[i].exp_out);
            if (VECS[i].op == OP_RD)
                check($sformatf("R5 vec%0d read", i), seen, VECS[i].exp_out);
            check($sformatf("R2/R4/R5 vec%0d fill", i), fill_cnt, VECS[i].exp_fill);
        end
        check("R5 state empty after drain", buf_state, 0);

        // R6 empty read
        do_reset();
        drive(0, 0, 1, 0, 0, 1, 16'h0);
        check("R6 empty read data", seen, 0);
        check("R6 empty_rd pulse", empty_rd, 1);
        check("R6 fill unchanged", fill_cnt, 0);
        drive(0, 0, 0, 0, 0, 1, 16'h0);
        check("R6 pulse one cycle", empty_rd, 0);

        // R10 underflow, R7 write clears it
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        check("R10 xudf on empty pull", xudf, 1);
        drive(1, 0, 0, 0, 0, 1, 16'h1122);
        check("R7 write clears xudf", xudf, 0);
        drive(1, 0, 0, 0, 0, 1, 16'h3344);
        drive(1, 0, 0, 0, 0, 1, 16'h5566);
        check("R8 overflow fill", fill_cnt, 4);
        check("R8 overflow rovr", rovr, 1);
        drive(0, 0, 0, 0, 1, 1, 16'h0077);
        check("R9 push in tx ignored", fill_cnt, 4);
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        check("R8 contents kept", seen, 16'h0011);
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        check("R10 xrdy before last", xrdy, 0);
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        check("R10 last byte", seen, 16'h0044);
        check("R10 xrdy on empty", xrdy, 1);
        check("R10 state empty", buf_state, 0);
        drive(0, 1, 0, 0, 0, 1, 16'h0099);
        check("R7 write clears xrdy", xrdy, 0);
        check("R3 byte write fill", fill_cnt, 1);
        drive(0, 0, 0, 1, 0, 1, 16'h0);
        check("R3 byte write value", seen, 16'h0099);

        // R7 read clears rovr; R4 R9 receive full
        drive(0, 0, 1, 0, 0, 1, 16'h0);
        check("R7 read clears rovr", rovr, 0);
        for (int k = 0; k < 4; k++) drive(0, 0, 0, 0, 1, 1, 16'h00A0 + 16'(k));
        check("R4 rrdy set", rrdy, 1);
        check("R4 state rx", buf_state, 2);
        drive(0, 0, 0, 0, 1, 1, 16'h00EE);
        check("R9 full push rovr", rovr, 1);
        check("R9 full push fill", fill_cnt, 4);
        drive(1, 0, 0, 0, 0, 1, 16'hFFFF);
        check("R8 write in rx dropped", fill_cnt, 4);
        drive(0, 0, 1, 0, 0, 1, 16'h0);
        check("R5 read pair", seen, 16'hA0A1);
        check("R7 read clears rrdy", rrdy, 0);
        drive(0, 0, 1, 0, 0, 0, 16'h0);
        check("R5 second pair", seen, 16'hA3A2);
        check("R5 state empty", buf_state, 0);

        // R11 priority: write beats push
        drive(1, 0, 0, 0, 1, 1, 16'hBEEF);
        check("R11 fill", fill_cnt, 2);
        check("R11 state", buf_state, 1);
        check("R11 rrdy untouched", rrdy, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule